// File: doc/BRIEF.md
# Eight-Channel Serial DAC Broadcast Writer

The block is a register-mapped controller for a bank of eight serial DACs. Software reaches it through an AXI4-Lite slave port. It stores one 16-bit code per channel. When a trigger bit goes from 0 to 1, the block shifts every stored code out to its DAC in a single sweep. Writing a channel register changes nothing at the DAC pins. The outputs move only after a trigger edge, and then all eight channels update together through one common load strobe.

All channels share one serial clock, and each channel has its own data line and chip-select. The serial clock runs at half the core clock, high for one core cycle and low for one. At the start of a sweep the codes are copied into shift registers, so register writes made during a sweep wait for the next trigger. If a trigger edge arrives while a sweep is running, it is held and causes exactly one more sweep. A busy flag tells software when the sweep has finished. The design uses one clock, shared by the register port and the serial engine.

Top module: `dac_bcast_writer`

## Requirements
- R1: Channel n (0..7) has a read/write code register at byte address 4*n. Bits 15:0 hold the code, and byte strobes 0 and 1 gate the low and high byte. A read returns the code zero-extended. Reads from unmapped addresses (0x28 and up) return 0.
- R2: The trigger register at address 0x20 stores bit 0 and reads it back. Only a write that changes the stored bit from 0 to 1 starts a sweep. Writing 1 while it is already 1, writing 0, or writing channel registers starts nothing.
- R3: Each channel's data line carries its code MSB first. The codes are captured when the sweep starts, so a channel write made during a sweep does not change the code being sent.
- R4: The serial clock is high for exactly one core cycle and low for at least one between rising edges. This gives 16 rising edges per sweep, two core cycles apart. Data changes only while the serial clock is low, so it is stable at every rising edge.
- R5: All chip-selects move together. They fall one core cycle before the first serial clock rise and return high two core cycles after the last rise. The serial clock stays low whenever the chip-selects are high.
- R6: The active-low load strobe is low for exactly two core cycles. It starts one core cycle after the chip-selects return high, and it is never low while any chip-select is low.
- R7: The status register at address 0x24 reads busy in bit 0. Busy is set from the cycle after the accepted trigger write until the load strobe ends, and reads 0 once the sweep is done.
- R8: A trigger edge that arrives during a sweep is held, and exactly one more sweep follows. Several edges during the same sweep still add only one sweep. That sweep sends the codes held at its own start.
- R9: After reset the serial clock is low, the chip-selects and the load strobe are high, busy is 0, and every register reads 0. No sweep runs until the first trigger edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core and register-port clock |
| rst_n | input | 1 | Active-low synchronous reset |
| s_awaddr | input | ADDR_W | Write address |
| s_awvalid | input | 1 | Write address valid |
| s_awready | output | 1 | Write address accepted |
| s_wdata | input | 32 | Write data |
| s_wstrb | input | 4 | Write byte strobes |
| s_wvalid | input | 1 | Write data valid |
| s_wready | output | 1 | Write data accepted |
| s_bresp | output | 2 | Write response, always OKAY |
| s_bvalid | output | 1 | Write response valid |
| s_bready | input | 1 | Write response taken |
| s_araddr | input | ADDR_W | Read address |
| s_arvalid | input | 1 | Read address valid |
| s_arready | output | 1 | Read address accepted |
| s_rdata | output | 32 | Read data |
| s_rresp | output | 2 | Read response, always OKAY |
| s_rvalid | output | 1 | Read data valid |
| s_rready | input | 1 | Read data taken |
| dac_sclk | output | 1 | Shared serial clock |
| dac_sdi | output | NCH | Per-channel serial data |
| dac_cs_n | output | NCH | Per-channel active-low chip-select |
| dac_load_n | output | 1 | Shared active-low load strobe |

## Verification
The bench checks level-versus-edge handling of the trigger. A design that fired on the level would start a second sweep when 1 is written again, and one that fired on any write would start a sweep on a write of 0. It changes a channel during a sweep to catch a missing snapshot, which would send a code that is half old and half new. It also sends back-to-back trigger edges during a sweep. A design that drops them would send too few sweeps, and one that counts them would send too many. Finally, the bench measures the setup and hold around the chip-select edges and the width and position of the load pulse. An off-by-one in the sweep counter would clip the last bit or let the load overlap the frame.

// File: rtl/dac_bcast_writer.sv
module dac_bcast_writer #(
  parameter int NCH    = 8,
  parameter int CODE_W = 16,
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] s_awaddr,
  input  logic              s_awvalid,
  output logic              s_awready,
  input  logic [31:0]       s_wdata,
  input  logic [3:0]        s_wstrb,
  input  logic              s_wvalid,
  output logic              s_wready,
  output logic [1:0]        s_bresp,
  output logic              s_bvalid,
  input  logic              s_bready,
  input  logic [ADDR_W-1:0] s_araddr,
  input  logic              s_arvalid,
  output logic              s_arready,
  output logic [31:0]       s_rdata,
  output logic [1:0]        s_rresp,
  output logic              s_rvalid,
  input  logic              s_rready,
  output logic              dac_sclk,
  output logic [NCH-1:0]    dac_sdi,
  output logic [NCH-1:0]    dac_cs_n,
  output logic              dac_load_n
);

  localparam int IDX_W     = (NCH > 1) ? $clog2(NCH) : 1;
  localparam int LAST_RISE = 2 * CODE_W - 1;
  localparam int CS_END    = 2 * CODE_W;
  localparam int LD_START  = 2 * CODE_W + 2;
  localparam int LD_END    = 2 * CODE_W + 3;
  localparam int CNT_W     = $clog2(LD_END + 1);
  localparam logic [ADDR_W-1:0] TRIG_A = ADDR_W'(4 * NCH);
  localparam logic [ADDR_W-1:0] STAT_A = ADDR_W'(4 * NCH + 4);

  logic [CODE_W-1:0] code_q  [NCH];
  logic [CODE_W-1:0] shreg_q [NCH];
  logic              trig_q, pend_q, run_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              bvalid_q, rvalid_q;
  logic [31:0]       rdata_q;
  logic              sclk_q, cs_q, load_q;

  logic              wr_fire, ar_fire, wr_ch, wr_trig, trig_edge;
  logic              start, sweep_end, busy;
  logic              run_n;
  logic [CNT_W-1:0]  cnt_n;
  logic [IDX_W-1:0]  widx, ridx;
  logic [31:0]       rd_word;
  logic              unused_in;

  assign unused_in = ^{s_wdata, s_wstrb, s_awaddr, s_araddr};

  assign wr_fire   = s_awvalid & s_wvalid & ~bvalid_q;
  assign s_awready = wr_fire;
  assign s_wready  = wr_fire;
  assign s_bvalid  = bvalid_q;
  assign s_bresp   = 2'b00;
  assign ar_fire   = s_arvalid & ~rvalid_q;
  assign s_arready = ar_fire;
  assign s_rvalid  = rvalid_q;
  assign s_rdata   = rdata_q;
  assign s_rresp   = 2'b00;

  assign widx      = s_awaddr[IDX_W+1:2];
  assign ridx      = s_araddr[IDX_W+1:2];
  assign wr_ch     = wr_fire && (s_awaddr < TRIG_A) && (s_awaddr[1:0] == 2'b00);
  assign wr_trig   = wr_fire && (s_awaddr == TRIG_A) && s_wstrb[0];
  assign trig_edge = wr_trig & s_wdata[0] & ~trig_q;

  assign start     = pend_q & ~run_q;
  assign sweep_end = run_q && (cnt_q == CNT_W'(LD_END));
  assign busy      = run_q | pend_q;

  always_comb begin
    run_n = run_q;
    cnt_n = cnt_q;
    if (start) begin
      run_n = 1'b1;
      cnt_n = '0;
    end else if (sweep_end) begin
      run_n = 1'b0;
      cnt_n = '0;
    end else if (run_q) begin
      cnt_n = cnt_q + 1'b1;
    end
  end

  always_comb begin
    rd_word = '0;
    if (s_araddr < TRIG_A && s_araddr[1:0] == 2'b00)
      rd_word[CODE_W-1:0] = code_q[ridx];
    else if (s_araddr == TRIG_A)
      rd_word[0] = trig_q;
    else if (s_araddr == STAT_A)
      rd_word[0] = busy;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bvalid_q <= 1'b0;
      rvalid_q <= 1'b0;
      rdata_q  <= '0;
      trig_q   <= 1'b0;
      for (int c = 0; c < NCH; c++) code_q[c] <= '0;
    end else begin
      if (wr_fire) bvalid_q <= 1'b1;
      else if (s_bready) bvalid_q <= 1'b0;
      if (ar_fire) begin
        rvalid_q <= 1'b1;
        rdata_q  <= rd_word;
      end else if (s_rready) begin
        rvalid_q <= 1'b0;
      end
      if (wr_trig) trig_q <= s_wdata[0];
      if (wr_ch)
        for (int b = 0; b < CODE_W; b++)
          if (s_wstrb[b/8]) code_q[widx][b] <= s_wdata[b];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      run_q  <= 1'b0;
      cnt_q  <= '0;
      sclk_q <= 1'b0;
      cs_q   <= 1'b1;
      load_q <= 1'b1;
    end else begin
      pend_q <= (pend_q & ~start) | trig_edge;
      run_q  <= run_n;
      cnt_q  <= cnt_n;
      sclk_q <= run_n && cnt_n[0] && (cnt_n <= CNT_W'(LAST_RISE));
      cs_q   <= !(run_n && (cnt_n <= CNT_W'(CS_END)));
      load_q <= !(run_n && (cnt_n >= CNT_W'(LD_START)) && (cnt_n <= CNT_W'(LD_END)));
    end
  end

  generate
    for (genvar g = 0; g < NCH; g++) begin : g_lane
      always_ff @(posedge clk) begin
        if (!rst_n)
          shreg_q[g] <= '0;
        else if (start)
          shreg_q[g] <= code_q[g];
        else if (run_q && cnt_q[0] && (cnt_q <= CNT_W'(LAST_RISE)))
          shreg_q[g] <= {shreg_q[g][CODE_W-2:0], 1'b0};
      end
      assign dac_sdi[g]  = shreg_q[g][CODE_W-1];
      assign dac_cs_n[g] = cs_q;
    end
  endgenerate

  assign dac_sclk   = sclk_q;
  assign dac_load_n = load_q;

endmodule

// File: rtl/dac_bcast_chk.sv
module dac_bcast_chk #(
  parameter int NCH = 8
) (
  input logic           clk,
  input logic           rst_n,
  input logic           sclk,
  input logic [NCH-1:0] sdi,
  input logic [NCH-1:0] cs_n,
  input logic           load_n,
  input logic           busy,
  input logic           trig_edge,
  input logic           bvalid,
  input logic           bready
);

  p_bresp_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    bvalid && !bready |=> bvalid);

  p_quiet_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (cs_n == '1) && load_n && !sclk);

  p_data_steady_r4: assert property (@(posedge clk) disable iff (!rst_n)
    sclk |-> $stable(sdi));

  p_sclk_half_r4: assert property (@(posedge clk) disable iff (!rst_n)
    sclk |=> !sclk);

  p_cs_common_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_n == '0) || (cs_n == '1));

  p_sclk_framed_r5: assert property (@(posedge clk) disable iff (!rst_n)
    sclk |-> (cs_n == '0));

  p_load_outside_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !load_n |-> (cs_n == '1));

  p_load_min_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(load_n) |=> !load_n);

  p_load_max_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !load_n && $past(!load_n) |=> load_n);

  p_edge_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
    trig_edge |=> busy);

endmodule

bind dac_bcast_writer dac_bcast_chk #(.NCH(NCH)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .sclk      (dac_sclk),
  .sdi       (dac_sdi),
  .cs_n      (dac_cs_n),
  .load_n    (dac_load_n),
  .busy      (busy),
  .trig_edge (trig_edge),
  .bvalid    (s_bvalid),
  .bready    (s_bready)
);

// File: tb/tb_dac_bcast_writer.sv
`timescale 1ns/1ps
module tb_dac_bcast_writer;
  localparam int NCH = 8;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic [5:0]  awaddr = '0, araddr = '0;
  logic        awvalid = 1'b0, wvalid = 1'b0, arvalid = 1'b0;
  logic [31:0] wdata = '0;
  logic [3:0]  wstrb = '0;
  logic        bready = 1'b1, rready = 1'b1;
  logic        awready, wready, bvalid, arready, rvalid;
  logic [1:0]  bresp, rresp;
  logic [31:0] rdata;
  logic        sclk, load_n;
  logic [NCH-1:0] sdi, cs_n;

  int n_chk = 0, n_bad = 0;
  logic [15:0] expc [NCH];

  always #10 clk = ~clk;

  dac_bcast_writer dut (
    .clk(clk), .rst_n(rst_n),
    .s_awaddr(awaddr), .s_awvalid(awvalid), .s_awready(awready),
    .s_wdata(wdata), .s_wstrb(wstrb), .s_wvalid(wvalid), .s_wready(wready),
    .s_bresp(bresp), .s_bvalid(bvalid), .s_bready(bready),
    .s_araddr(araddr), .s_arvalid(arvalid), .s_arready(arready),
    .s_rdata(rdata), .s_rresp(rresp), .s_rvalid(rvalid), .s_rready(rready),
    .dac_sclk(sclk), .dac_sdi(sdi), .dac_cs_n(cs_n), .dac_load_n(load_n)
  );

  // frame monitor
  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int frames = 0, loads = 0, nbits = 0, last_bits = 0;
  int cs_fall = 0, cs_rise = 0, last_rise = 0, ld_fall = 0;
  int lead = 0, tail = 0, gap = 0, ldw = 0, bad_per = 0, bad_cs = 0;
  logic [15:0] msh [NCH];
  logic [15:0] mcap [NCH];
  logic p_sclk = 1'b0, p_cs = 1'b1, p_ld = 1'b1;

  always @(negedge clk) begin
    if (rst_n) begin
      if (cs_n != '0 && cs_n != '1) bad_cs++;
      if (p_cs && !cs_n[0]) begin cs_fall = cyc; nbits = 0; end
      if (!p_sclk && sclk) begin
        if (nbits == 0) lead = cyc - cs_fall;
        else if (cyc - last_rise != 2) bad_per++;
        last_rise = cyc;
        for (int c = 0; c < NCH; c++) msh[c] = {msh[c][14:0], sdi[c]};
        nbits++;
      end
      if (!p_cs && cs_n[0]) begin
        cs_rise = cyc; tail = cyc - last_rise; last_bits = nbits; frames++;
        for (int c = 0; c < NCH; c++) mcap[c] = msh[c];
      end
      if (p_ld && !load_n) begin ld_fall = cyc; gap = cyc - cs_rise; end
      if (!p_ld && load_n) begin ldw = cyc - ld_fall; loads++; end
    end
    p_sclk = sclk; p_cs = cs_n[0]; p_ld = load_n;
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic finish_sim();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  task automatic axi_wr(input logic [5:0] a, input logic [31:0] d, input logic [3:0] s);
    @(negedge clk);
    awaddr = a; wdata = d; wstrb = s; awvalid = 1'b1; wvalid = 1'b1;
    #1;
    while (!awready) begin @(negedge clk); #1; end
    @(negedge clk);
    awvalid = 1'b0; wvalid = 1'b0;
  endtask

  task automatic axi_rd(input logic [5:0] a, output logic [31:0] d);
    @(negedge clk);
    araddr = a; arvalid = 1'b1;
    #1;
    while (!arready) begin @(negedge clk); #1; end
    @(negedge clk);
    d = rdata; arvalid = 1'b0;
  endtask

  task automatic wait_idle();
    logic [31:0] st;
    for (int i = 0; i < 400; i++) begin
      axi_rd(6'h24, st);
      if (!st[0]) return;
    end
    chk(1'b0, "R7 busy never cleared", 1, 0);
  endtask

  task automatic check_frame(input string req);
    chk(last_bits == 16, {req, " bit count"}, last_bits, 16);
    for (int c = 0; c < NCH; c++) chk(mcap[c] == expc[c], {req, " channel code"}, mcap[c], expc[c]);
    chk(lead == 1, "R5 cs lead", lead, 1);
    chk(tail == 2, "R5 cs tail", tail, 2);
    chk(gap == 1, "R6 load gap", gap, 1);
    chk(ldw == 2, "R6 load width", ldw, 2);
    chk(bad_per == 0, "R4 sclk period", bad_per, 0);
    chk(bad_cs == 0, "R5 common cs", bad_cs, 0);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    chk(sclk == 1'b0, "R9 sclk idle", sclk, 0);
    chk(cs_n == '1, "R9 cs idle", cs_n, 8'hFF);
    chk(load_n == 1'b1, "R9 load idle", load_n, 1);
    axi_rd(6'h24, d); chk(d == 0, "R9 busy after reset", d, 0);
    axi_rd(6'h1C, d); chk(d == 0, "R9 channel after reset", d, 0);
    axi_rd(6'h20, d); chk(d == 0, "R9 trigger after reset", d, 0);
  endtask

  task automatic t_regs();
    logic [31:0] d;
    logic [15:0] v [NCH] = '{16'hFFFF, 16'h0000, 16'h8001, 16'h5AA5, 16'h1234, 16'hC3C3, 16'h7FFE, 16'h0F0F};
    for (int c = 0; c < NCH; c++) begin
      axi_wr(6'(4*c), {16'hDEAD, v[c]}, 4'hF);
      expc[c] = v[c];
    end
    for (int c = 0; c < NCH; c++) begin
      axi_rd(6'(4*c), d);
      chk(d == {16'h0, expc[c]}, "R1 readback", d, expc[c]);
    end
    axi_wr(6'h1C, 32'h0000_00AA, 4'b0001);
    expc[7] = {expc[7][15:8], 8'hAA};
    axi_rd(6'h1C, d); chk(d == {16'h0, expc[7]}, "R1 byte strobe", d, expc[7]);
    axi_rd(6'h28, d); chk(d == 0, "R1 unmapped read", d, 0);
  endtask

  task automatic t_no_trig();
    int f0 = frames;
    repeat (60) @(negedge clk);
    chk(frames == f0, "R2 channel writes alone", frames - f0, 0);
    chk(cs_n == '1, "R2 cs stays high", cs_n, 8'hFF);
  endtask

  task automatic t_sweep();
    logic [31:0] d;
    int f0 = frames;
    axi_wr(6'h20, 32'h1, 4'hF);
    axi_rd(6'h24, d); chk(d[0] == 1'b1, "R7 busy during sweep", d, 1);
    wait_idle();
    repeat (2) @(negedge clk);
    chk(frames == f0 + 1, "R2 one sweep per edge", frames - f0, 1);
    check_frame("R3");
    axi_rd(6'h24, d); chk(d[0] == 1'b0, "R7 busy after sweep", d, 0);
    axi_rd(6'h20, d); chk(d == 1, "R2 trigger readback", d, 1);
  endtask

  task automatic t_hold();
    int f0 = frames;
    axi_wr(6'h20, 32'h1, 4'hF);
    repeat (50) @(negedge clk);
    chk(frames == f0, "R2 rewrite of 1", frames - f0, 0);
    axi_wr(6'h20, 32'h0, 4'hF);
    repeat (50) @(negedge clk);
    chk(frames == f0, "R2 write of 0", frames - f0, 0);
    chk(loads == f0, "R2 no load strobe", loads, f0);
  endtask

  task automatic t_snapshot();
    int f0 = frames;
    logic [15:0] nv = 16'hA50F;
    axi_wr(6'h20, 32'h1, 4'hF);
    repeat (6) @(negedge clk);
    axi_wr(6'h08, {16'h0, nv}, 4'hF);
    wait_idle();
    repeat (2) @(negedge clk);
    chk(frames == f0 + 1, "R3 snapshot sweep count", frames - f0, 1);
    check_frame("R3 snapshot");
    expc[2] = nv;
    axi_wr(6'h20, 32'h0, 4'hF);
    axi_wr(6'h20, 32'h1, 4'hF);
    wait_idle();
    repeat (2) @(negedge clk);
    chk(mcap[2] == nv, "R3 new code on next trigger", mcap[2], nv);
  endtask

  task automatic t_queue();
    int f0;
    axi_wr(6'h20, 32'h0, 4'hF);
    f0 = frames;
    axi_wr(6'h20, 32'h1, 4'hF);
    repeat (4) @(negedge clk);
    axi_wr(6'h04, 32'h0000_3C3C, 4'hF);
    expc[1] = 16'h3C3C;
    axi_wr(6'h20, 32'h0, 4'hF);
    axi_wr(6'h20, 32'h1, 4'hF);
    axi_wr(6'h20, 32'h0, 4'hF);
    axi_wr(6'h20, 32'h1, 4'hF);
    chk(frames == f0, "R8 edges land inside first sweep", frames - f0, 0);
    wait_idle();
    repeat (60) @(negedge clk);
    chk(frames == f0 + 2, "R8 exactly one extra sweep", frames - f0, 2);
    chk(loads == f0 + 2, "R8 load per sweep", loads - f0, 2);
    check_frame("R8");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    chk(1'b0, "watchdog expired", cyc, 0);
    finish_sim();
  end

  initial begin
    for (int c = 0; c < NCH; c++) begin expc[c] = '0; msh[c] = '0; mcap[c] = '0; end
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    t_regs();
    t_no_trig();
    t_sweep();
    t_hold();
    t_snapshot();
    t_queue();
    repeat (5) @(negedge clk);
    finish_sim();
  end
endmodule